// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block gathers single-cycle event pulses into a host-visible interrupt status word. The pulses come from firmware, board signals and DMA channels. A separate enable mask decides which status bits may drive the single `irq` line. The host clears a status bit by writing 1 to its position. Writing 0 leaves a bit unchanged.

DMA activity is held in a second-level status word with its own per-channel bits. Those bits are reduced into three summary bits of the main word. A programmable hold-off, counted in ticks of 32 microseconds, delays the interrupt so that several events can be served with one interrupt. A high-priority receive event cuts the hold-off short.

Software reaches four registers through a flat 32-bit port with a 2-bit select. Reads return data one cycle after the select is presented.

Top module: `host_irq_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `irq` is 0 and every register reads 0.
- R2: A pulse on `host_evt` sets the matching main status bit at the next clock edge. Only bits 28, 26, 25, 7, 6, 3, 1 and 0 can be set this way; every other `host_evt` bit is ignored. `reg_rdata` shows the register chosen by `reg_addr` (0 = main status, 1 = enable mask, 2 = DMA status, 3 = hold-off value) one clock after the select.
- R3: A write to select 0 clears each main status bit whose `reg_wdata` bit is 1 and leaves every bit whose data bit is 0. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: The DMA status word (select 2) implements bit 31 (DMA error), bit 30 (high-priority receive), bits 17:16 (receive channels 1..0) and bits 1:0 (transmit channels 1..0). `dma_evt` sets these bits, a write of 1 at select 2 clears them, and every other bit reads 0.
- R5: Main bit 31 reads as the OR of DMA bits 30, 17 and 16. Main bit 29 reads as DMA bit 31. Main bit 27 reads as the OR of DMA bits 1 and 0. Writing 1 to these three positions at select 0 has no effect.
- R6: The enable mask (select 1) is writable in every implemented main bit (31, 29, 27 and the bits of R2) and reads 0 elsewhere. Status bits whose mask bit is 0 never cause `irq`.
- R7: The hold-off value (select 3, COAL_W bits) counts in ticks of TICK_CYCLES clocks. Suppose the masked status becomes non-zero while `irq` is low and no hold-off is running, and N is non-zero. Then `irq` rises N*TICK_CYCLES+1 edges after the edge that made the masked status non-zero.
- R8: With a hold-off value of 0, `irq` rises at the edge after the masked status becomes non-zero.
- R9: When DMA bit 30 is set and mask bit 31 is 1, `irq` rises at the next edge, even while a hold-off is running.
- R10: Once high, `irq` stays high while the masked status is non-zero. It falls at the edge after the masked status becomes zero. A later event starts a new hold-off.
- R11: If the masked status returns to zero before the hold-off ends, the hold-off is abandoned and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, one cycle after the select |
| host_evt | input | 32 | Event pulses into the main status word |
| dma_evt | input | 32 | Event pulses into the DMA status word |
| irq | output | 1 | Host interrupt line |

## Verification
Two functions can land on the same status bit in the same cycle: a hardware event setting it and a host write-1 clearing it. The bench provokes this by driving `host_evt` (and, separately, `dma_evt`) in the very cycle of a clear aimed at that bit. The readback must still show the bit set, and `irq` must not drop.

The bench also collides a high-priority receive event with a running hold-off. `irq` must rise at the next edge, not at the end of the count. A behavioural reference model judges every cycle, comparing `irq` and `reg_rdata` on each clock.

// File: rtl/hic_pkg.sv
package hic_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'd0,
    SEL_MASK = 2'd1,
    SEL_DMA  = 2'd2,
    SEL_COAL = 2'd3
  } reg_sel_e;

  // main status bits driven directly by events
  localparam logic [DATA_W-1:0] DIRECT_BITS = 32'h1600_00CB;
  // main status bits computed from the DMA word
  localparam logic [DATA_W-1:0] SUMMARY_BITS = 32'hA800_0000;
  localparam logic [DATA_W-1:0] MAIN_BITS = DIRECT_BITS | SUMMARY_BITS;
  // implemented DMA status bits
  localparam logic [DATA_W-1:0] DMA_BITS = 32'hC003_0003;

  localparam int SUM_RX_POS  = 31;
  localparam int SUM_ERR_POS = 29;
  localparam int SUM_TX_POS  = 27;
  localparam int DMA_ERR_POS = 31;
  localparam int DMA_HPR_POS = 30;
  localparam int DMA_RX1_POS = 17;
  localparam int DMA_RX0_POS = 16;
  localparam int DMA_TX1_POS = 1;
  localparam int DMA_TX0_POS = 0;

endpackage

// File: rtl/hic_w1c_bank.sv
module hic_w1c_bank #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (IMPL[i]) begin : g_ff
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= (bit_q & ~clr_i[i]) | set_i[i];
      end
      assign q_o[i] = bit_q;
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end

  logic unused_inputs;
  assign unused_inputs = ^{set_i & ~IMPL, clr_i & ~IMPL};

  // R3
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & IMPL)) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  // R3
  no_clr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o)));

endmodule

// File: rtl/hic_coalesce_timer.sv
module hic_coalesce_timer #(
  parameter int COAL_W      = 8,
  parameter int TICK_CYCLES = 1600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_i,
  input  logic              bypass_i,
  input  logic [COAL_W-1:0] coal_i,
  output logic              irq_o
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_CYCLES - 1);

  logic              irq_q;
  logic              run_q;
  logic [PW-1:0]     presc_q;
  logic [COAL_W-1:0] left_q;
  logic              tick_end;
  logic              expired;
  logic              irq_d;

  assign tick_end = (presc_q == PRESC_LAST);
  assign expired  = run_q && (left_q == COAL_W'(1)) && tick_end;

  always_comb begin
    if (irq_q) irq_d = pend_i;
    else       irq_d = pend_i && ((coal_i == '0) || bypass_i || expired);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      run_q   <= 1'b0;
      presc_q <= '0;
      left_q  <= '0;
    end else begin
      irq_q <= irq_d;
      if (irq_q || !pend_i || irq_d) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        if (tick_end) begin
          presc_q <= '0;
          left_q  <= left_q - COAL_W'(1);
        end else begin
          presc_q <= presc_q + PW'(1);
        end
      end else begin
        run_q   <= 1'b1;
        presc_q <= '0;
        left_q  <= coal_i;
      end
    end
  end

  assign irq_o = irq_q;

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && pend_i) |=> irq_q);

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_i |=> !irq_q);

  // R9
  bypass_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass_i && pend_i) |=> irq_q);

  // R8
  zero_coal_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_i && coal_i == '0) |=> irq_q);

endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import hic_pkg::*;
#(
  parameter int COAL_W      = 8,
  parameter int TICK_CYCLES = 1600
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] host_evt,
  input  logic [31:0] dma_evt,
  output logic        irq
);

  logic [DATA_W-1:0] clr_main, clr_dma;
  logic [DATA_W-1:0] direct_q, dma_q;
  logic [DATA_W-1:0] summary, status;
  logic [DATA_W-1:0] mask_q;
  logic [COAL_W-1:0] coal_q;
  logic [DATA_W-1:0] rdata_q;
  logic              pend, bypass;
  reg_sel_e          sel;

  assign sel      = reg_sel_e'(reg_addr);
  assign clr_main = (reg_we && sel == SEL_MAIN) ? (reg_wdata & DIRECT_BITS) : '0;
  assign clr_dma  = (reg_we && sel == SEL_DMA)  ? (reg_wdata & DMA_BITS)    : '0;

  hic_w1c_bank #(.WIDTH(DATA_W), .IMPL(DIRECT_BITS)) u_main_bank (
    .clk  (clk),
    .rst  (rst),
    .set_i(host_evt & DIRECT_BITS),
    .clr_i(clr_main),
    .q_o  (direct_q)
  );

  hic_w1c_bank #(.WIDTH(DATA_W), .IMPL(DMA_BITS)) u_dma_bank (
    .clk  (clk),
    .rst  (rst),
    .set_i(dma_evt & DMA_BITS),
    .clr_i(clr_dma),
    .q_o  (dma_q)
  );

  always_comb begin
    summary = '0;
    summary[SUM_RX_POS]  = dma_q[DMA_HPR_POS] | dma_q[DMA_RX1_POS] | dma_q[DMA_RX0_POS];
    summary[SUM_ERR_POS] = dma_q[DMA_ERR_POS];
    summary[SUM_TX_POS]  = dma_q[DMA_TX1_POS] | dma_q[DMA_TX0_POS];
  end

  assign status = direct_q | summary;
  assign pend   = |(status & mask_q);
  assign bypass = dma_q[DMA_HPR_POS] & mask_q[SUM_RX_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      coal_q <= '0;
    end else if (reg_we) begin
      if (sel == SEL_MASK) mask_q <= reg_wdata & MAIN_BITS;
      if (sel == SEL_COAL) coal_q <= reg_wdata[COAL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (sel)
        SEL_MAIN: rdata_q <= status;
        SEL_MASK: rdata_q <= mask_q;
        SEL_DMA:  rdata_q <= dma_q;
        SEL_COAL: rdata_q <= DATA_W'(coal_q);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;

  hic_coalesce_timer #(.COAL_W(COAL_W), .TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .pend_i  (pend),
    .bypass_i(bypass),
    .coal_i  (coal_q),
    .irq_o   (irq)
  );

  // R6
  masked_only_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0 && !reg_we) |=> !irq);

  // R5
  summary_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && sel == SEL_MAIN && dma_q[DMA_ERR_POS]) |=> status[SUM_ERR_POS]);

endmodule

// File: tb/tb_host_irq_ctrl.sv
module tb_host_irq_ctrl;

  localparam int TICK = 4;
  localparam logic [31:0] DIR_M = 32'h1600_00CB;
  localparam logic [31:0] DMA_M = 32'hC003_0003;
  localparam logic [31:0] ALL_M = 32'hBE00_00CB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] host_evt = '0;
  logic [31:0] dma_evt = '0;
  logic        irq;

  always #10 clk = ~clk;

  host_irq_ctrl #(.COAL_W(8), .TICK_CYCLES(TICK)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_evt(host_evt), .dma_evt(dma_evt), .irq(irq)
  );

  logic [31:0] m_dir, m_dma, m_mask, m_rdata;
  logic [7:0]  m_coal;
  logic        m_irq, m_run;
  int          m_cnt;
  int          checks = 0;
  int          fails = 0;
  int          cyc_cnt = 0;
  string       cur_req = "R1";
  bit          cmp_on = 1'b0;

  always @(posedge clk) begin : ref_model
    logic [31:0] sum, stat;
    logic pend, byp, nirq;
    if (rst) begin
      m_dir = '0; m_dma = '0; m_mask = '0; m_rdata = '0;
      m_coal = '0; m_irq = 1'b0; m_run = 1'b0; m_cnt = 0;
    end else begin
      sum = '0;
      sum[31] = m_dma[30] | m_dma[17] | m_dma[16];
      sum[29] = m_dma[31];
      sum[27] = m_dma[1] | m_dma[0];
      stat = m_dir | sum;
      case (reg_addr)
        2'd0: m_rdata = stat;
        2'd1: m_rdata = m_mask;
        2'd2: m_rdata = m_dma;
        default: m_rdata = {24'd0, m_coal};
      endcase
      pend = |(stat & m_mask);
      byp  = m_dma[30] & m_mask[31];
      if (m_irq) nirq = pend;
      else nirq = pend && (m_coal == 0 || byp || (m_run && m_cnt == 1));
      if (m_irq || !pend || nirq) m_run = 1'b0;
      else if (m_run) m_cnt = m_cnt - 1;
      else begin m_run = 1'b1; m_cnt = m_coal * TICK; end
      m_irq = nirq;
      if (reg_we && reg_addr == 2'd0) m_dir = m_dir & ~reg_wdata;
      if (reg_we && reg_addr == 2'd2) m_dma = m_dma & ~reg_wdata;
      if (reg_we && reg_addr == 2'd1) m_mask = reg_wdata & ALL_M;
      if (reg_we && reg_addr == 2'd3) m_coal = reg_wdata[7:0];
      m_dir = m_dir | (host_evt & DIR_M);
      m_dma = m_dma | (dma_evt & DMA_M);
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("irq", {31'd0, irq}, {31'd0, m_irq});
      check("rdata", reg_rdata, m_rdata);
    end
  end

  task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] d,
                       input logic [31:0] he, input logic [31:0] de);
    reg_we = we; reg_addr = a; reg_wdata = d; host_evt = he; dma_evt = de;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; host_evt = '0; dma_evt = '0;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    reg_addr = a;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual %0d expected below 20000 cycles", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    cmp_on = 1'b1;
    // R1: reset state on every select
    for (int a = 0; a < 4; a++) idle(1, 2'(a));
    rst = 1'b0;
    idle(1, 2'd0);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);

    // R6: mask write and readback of implemented bits
    cur_req = "R6";
    drive(1'b1, 2'd1, 32'hFFFF_FFFF, '0, '0);
    idle(2, 2'd1);

    // R8: zero hold-off fires at the next edge
    cur_req = "R8";
    drive(1'b0, 2'd0, '0, 32'h0000_0001, '0);
    idle(3, 2'd0);

    // R2: remaining direct bits plus ignored positions
    cur_req = "R2";
    drive(1'b0, 2'd0, '0, 32'h1600_00CA | 32'h0100_0030, '0);
    idle(2, 2'd0);

    // R3: write of zeros, then single clear, then collision of event and clear
    cur_req = "R3";
    drive(1'b1, 2'd0, 32'h0000_0000, '0, '0);
    idle(1, 2'd0);
    drive(1'b1, 2'd0, 32'h0000_0001, '0, '0);
    idle(1, 2'd0);
    drive(1'b1, 2'd0, 32'h0000_0008, 32'h0000_0008, '0);
    idle(2, 2'd0);

    // R10: clearing everything drops irq
    cur_req = "R10";
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, '0, '0);
    idle(3, 2'd0);

    // R4: DMA word set, readback, partial clear, collision on a DMA bit
    cur_req = "R4";
    drive(1'b0, 2'd2, '0, '0, 32'hFFFF_FFFF);
    idle(2, 2'd2);
    drive(1'b1, 2'd2, 32'h0001_0001, '0, 32'h0000_0001);
    idle(2, 2'd2);

    // R5: summary positions ignore write-1 at main, then fold follows DMA clears
    cur_req = "R5";
    drive(1'b1, 2'd0, 32'hA800_0000, '0, '0);
    idle(2, 2'd0);
    drive(1'b1, 2'd2, 32'h8000_0000, '0, '0);
    idle(1, 2'd0);
    drive(1'b1, 2'd2, 32'hFFFF_FFFF, '0, '0);
    idle(3, 2'd0);

    // R6: masked-off events do not raise irq; enabling them does
    cur_req = "R6";
    drive(1'b1, 2'd1, 32'h0000_0000, '0, '0);
    drive(1'b0, 2'd0, '0, 32'h0000_00C0, 32'h0000_0002);
    idle(4, 2'd0);
    drive(1'b1, 2'd1, 32'h0000_0040, '0, '0);
    idle(3, 2'd0);
    drive(1'b1, 2'd0, 32'h0000_0040, '0, '0);
    idle(3, 2'd0);
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, '0, '0);
    drive(1'b1, 2'd2, 32'hFFFF_FFFF, '0, '0);
    drive(1'b1, 2'd1, 32'hFFFF_FFFF, '0, '0);
    idle(2, 2'd1);

    // R7: hold-off of three ticks
    cur_req = "R7";
    drive(1'b1, 2'd3, 32'h0000_0003, '0, '0);
    idle(1, 2'd3);
    drive(1'b0, 2'd0, '0, 32'h0000_0040, '0);
    idle(18, 2'd0);
    drive(1'b1, 2'd0, 32'h0000_0040, '0, '0);
    idle(3, 2'd0);

    // R11: abandon a hold-off, then a fresh one runs in full
    cur_req = "R11";
    drive(1'b0, 2'd0, '0, 32'h0000_0002, '0);
    idle(6, 2'd0);
    drive(1'b1, 2'd0, 32'h0000_0002, '0, '0);
    idle(20, 2'd0);
    drive(1'b0, 2'd0, '0, 32'h1000_0000, '0);
    idle(16, 2'd0);
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, '0, '0);
    idle(2, 2'd0);

    // R9: high-priority receive cuts a running hold-off
    cur_req = "R9";
    drive(1'b1, 2'd3, 32'h0000_000A, '0, '0);
    drive(1'b0, 2'd0, '0, 32'h0000_0001, '0);
    idle(5, 2'd0);
    drive(1'b0, 2'd2, '0, '0, 32'h4000_0000);
    idle(3, 2'd2);
    drive(1'b1, 2'd2, 32'h4000_0000, '0, '0);
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, '0, '0);
    idle(2, 2'd0);
    // bypass without its mask bit does nothing
    drive(1'b1, 2'd1, 32'h0000_0001, '0, '0);
    drive(1'b0, 2'd0, '0, '0, 32'h4000_0000);
    idle(6, 2'd0);
    drive(1'b1, 2'd2, 32'hFFFF_FFFF, '0, '0);
    drive(1'b1, 2'd1, 32'hFFFF_FFFF, '0, '0);

    // R10: irq held through new events and partial clears, then new hold-off
    cur_req = "R10";
    drive(1'b1, 2'd3, 32'h0000_0001, '0, '0);
    drive(1'b0, 2'd0, '0, 32'h0000_0080, '0);
    idle(6, 2'd0);
    drive(1'b0, 2'd0, '0, 32'h0200_0000, '0);
    drive(1'b1, 2'd0, 32'h0000_0080, '0, '0);
    idle(3, 2'd0);
    drive(1'b1, 2'd0, 32'h0200_0000, 32'h0200_0000, '0);
    idle(2, 2'd0);
    drive(1'b1, 2'd0, 32'h0200_0000, '0, '0);
    idle(2, 2'd0);
    drive(1'b0, 2'd0, '0, 32'h0000_0008, '0);
    idle(8, 2'd0);
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, '0, '0);
    idle(3, 2'd0);
    check("R10 irq low at end", {31'd0, irq}, 32'd0);

    finish_run();
  end

endmodule